// File: doc/BRIEF.md
# Scatter-Gather DMA Address Sequencer

This block produces the host write address for every word of a long DMA transfer, so that the processor does not have to intervene while the transfer is running. A small local table holds one page base address per entry. The processor fills the table through a simple write port while the block is idle. After `start`, the block walks the table from entry 0. It loads each entry's base into a write pointer and steps the pointer once per accepted word. When the last word of a page is taken, it fetches the next entry.

Each table entry also carries a flag in its top bit that marks the final page the transfer may use. When that page is full, the block drops its address-valid output and reports completion. If the data path still pushes words after that point, the block flags an overrun. Fetching an entry costs one cycle, during which the block holds off the data path.

Top module: `sg_addr_seq`

## Requirements
- R1: After a synchronous active-low reset, `word_rdy`, `addr_vld`, `done` and `overrun` are all low.
- R2: A `start` seen while idle or finished selects table entry 0. The cycle after `start` is a fetch cycle with `word_rdy` low. One cycle later `addr_vld` is high and `addr_out` equals bits [ADDR_W-1:0] of entry 0 with its low PAGE_W bits cleared.
- R3: A word is accepted only in a cycle where `word_stb` and `word_rdy` are both high. Within a page, each accepted word raises `addr_out` by exactly one in the next cycle. A strobe while `word_rdy` is low is not counted.
- R4: Once the word at page offset all-ones is accepted, on a page not flagged as last, `word_rdy` is low for exactly one cycle. After that cycle `addr_out` is the next entry's base with the offset at zero.
- R5: Bit ADDR_W of an entry (bit 31 with the default ADDR_W=31) marks the last page. Once the final word of that page is accepted, `addr_vld` and `word_rdy` go low and `done` goes high. They stay that way until `start` or `abort`.
- R6: The highest table entry (index TBL_DEPTH-1) is treated as the last page even when its flag bit is clear.
- R7: A `word_stb` while finished raises `overrun`. `overrun` and `done` then stay high, with `addr_vld` low, until `start` or `abort`.
- R8: Table writes are ignored while a transfer is fetching or running. They take effect while the block is idle or finished.
- R9: `abort` returns the block to idle in the next cycle and clears `done` and `overrun`. It takes priority over `start` in the same cycle.
- R10: A `start` while a transfer is fetching or running has no effect on the address sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_we | input | 1 | Table write enable |
| tbl_idx | input | IDX_W | Table entry index to write |
| tbl_data | input | ADDR_W+1 | Entry value: last flag in the MSB, page base below it |
| start | input | 1 | Begin a transfer from entry 0 |
| abort | input | 1 | Cancel the transfer and return to idle |
| word_stb | input | 1 | Data path offers a word |
| word_rdy | output | 1 | Block can accept a word this cycle |
| addr_out | output | ADDR_W | Host write address for the current word |
| addr_vld | output | 1 | `addr_out` is meaningful |
| done | output | 1 | Last permitted page has been filled |
| overrun | output | 1 | A word arrived after the last page was filled |

## Verification
The bench builds the block with PAGE_W=2 and TBL_DEPTH=8, keeping ADDR_W=31 so the last flag sits in bit 31. Four-word pages put page wrap, the fetch stall and several consecutive fetches within a few dozen cycles. An eight-entry table makes it cheap to run a transfer through every entry and reach the forced last page at the top index. Entry values with nonzero low bits show that the page offset is cleared on load.

// File: rtl/sg_pkg.sv
// Package: shared types for the scatter-gather address sequencer.
// Assumes: nothing beyond standard SystemVerilog.
package sg_pkg;

    // Sequencer phase: idle, fetching a table entry, issuing addresses, finished.
    typedef enum logic [1:0] {
        SG_IDLE  = 2'd0,
        SG_FETCH = 2'd1,
        SG_RUN   = 2'd2,
        SG_SPENT = 2'd3
    } sg_state_e;

endpackage

// File: rtl/sg_table.sv
// Module: sg_table
// Holds one page number and one last-page flag per entry.
// Writes are refused while a transfer is busy. Reads are combinational.
// Assumes: the offset bits of a written entry carry no meaning, so they are not stored.
module sg_table #(
    parameter int ADDR_W    = 31,
    parameter int PAGE_W    = 12,
    parameter int TBL_DEPTH = 256,
    localparam int IDX_W    = $clog2(TBL_DEPTH),
    localparam int PNUM_W   = ADDR_W - PAGE_W,
    localparam int ENTRY_W  = ADDR_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic               busy,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [PNUM_W-1:0]  rd_page,
    output logic               rd_last
);

    localparam int STORE_W = PNUM_W + 1;

    logic [STORE_W-1:0] mem [TBL_DEPTH];
    wire                unused_offset_bits = ^wr_data[PAGE_W-1:0];

    // Store flag and page number on an accepted write.
    always_ff @(posedge clk) begin
        if (wr_en && !busy) begin
            mem[wr_idx] <= {wr_data[ENTRY_W-1], wr_data[ADDR_W-1:PAGE_W]};
        end
    end

    // Present the selected entry to the fetch logic.
    always_comb begin
        rd_last = mem[rd_idx][STORE_W-1];
        rd_page = mem[rd_idx][PNUM_W-1:0];
    end

    AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy) |=> (mem[$past(wr_idx)] == $past(mem[wr_idx]))) // R8
        else $error("table entry changed during an active transfer");

endmodule

// File: rtl/sg_ptr.sv
// Module: sg_ptr
// Write pointer split into page number and in-page offset.
// A load takes a new page with offset zero. An increment steps the offset.
// Assumes: load and inc are never high together. Page size is 2**PAGE_W words.
module sg_ptr #(
    parameter int ADDR_W  = 31,
    parameter int PAGE_W  = 12,
    localparam int PNUM_W = ADDR_W - PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PNUM_W-1:0] page_in,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr,
    output logic              page_end
);

    logic [PNUM_W-1:0] page_q;
    logic [PAGE_W-1:0] off_q;

    // Track the current page and the offset within it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
            off_q  <= '0;
        end else if (load) begin
            page_q <= page_in;
            off_q  <= '0;
        end else if (inc) begin
            off_q  <= off_q + 1'b1;
        end
    end

    // Form the address and flag the last word slot of the page.
    always_comb begin
        addr     = {page_q, off_q};
        page_end = &off_q;
    end

    AST_OFFSET_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !page_end) |=> (addr == $past(addr) + 1'b1)) // R3
        else $error("address did not advance by one");

    AST_LOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (addr[PAGE_W-1:0] == '0)) // R2
        else $error("new page did not start at offset zero");

endmodule

// File: rtl/sg_ctrl.sv
// Module: sg_ctrl
// Sequencer control: table index, fetch/run/finished phases, done and overrun.
// One fetch cycle per page, during which the data path is held off.
// Assumes: the table read is combinational on rd_idx. TBL_DEPTH >= 2 and is a power of two.
module sg_ctrl
    import sg_pkg::*;
#(
    parameter int TBL_DEPTH = 256,
    localparam int IDX_W    = $clog2(TBL_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic             word_stb,
    input  logic             page_end,
    input  logic             ent_last,
    output logic [IDX_W-1:0] rd_idx,
    output logic             busy,
    output logic             load,
    output logic             inc,
    output logic             word_rdy,
    output logic             addr_vld,
    output logic             done,
    output logic             overrun
);

    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(TBL_DEPTH - 1);

    sg_state_e        st_q;
    logic [IDX_W-1:0] idx_q;
    logic             last_q;
    logic             done_q;
    logic             ovr_q;

    // Phase sequencing, table index, completion and overrun flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SG_IDLE;
            idx_q  <= '0;
            last_q <= 1'b0;
            done_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else if (abort) begin
            st_q   <= SG_IDLE;
            done_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            unique case (st_q)
                SG_IDLE: begin
                    if (start) begin
                        st_q  <= SG_FETCH;
                        idx_q <= '0;
                    end
                end
                SG_FETCH: begin
                    last_q <= ent_last || (idx_q == TOP_IDX);
                    idx_q  <= idx_q + 1'b1;
                    st_q   <= SG_RUN;
                end
                SG_RUN: begin
                    if (word_stb && page_end) begin
                        if (last_q) begin
                            st_q   <= SG_SPENT;
                            done_q <= 1'b1;
                        end else begin
                            st_q   <= SG_FETCH;
                        end
                    end
                end
                SG_SPENT: begin
                    if (start) begin
                        st_q   <= SG_FETCH;
                        idx_q  <= '0;
                        done_q <= 1'b0;
                        ovr_q  <= 1'b0;
                    end else if (word_stb) begin
                        ovr_q  <= 1'b1;
                    end
                end
                default: st_q <= SG_IDLE;
            endcase
        end
    end

    // Decode phase into strobes for the table and pointer and the block outputs.
    always_comb begin
        rd_idx   = idx_q;
        busy     = (st_q == SG_FETCH) || (st_q == SG_RUN);
        load     = (st_q == SG_FETCH) && !abort;
        inc      = (st_q == SG_RUN) && word_stb && !abort;
        word_rdy = (st_q == SG_RUN);
        addr_vld = (st_q == SG_RUN);
        done     = done_q;
        overrun  = ovr_q;
    end

    AST_FETCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SG_FETCH && !abort) |=> (st_q == SG_RUN)) // R4
        else $error("fetch took more than one cycle");

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SG_RUN && start && !abort && !word_stb) |=> (st_q == SG_RUN && $stable(idx_q))) // R10
        else $error("start disturbed a running transfer");

endmodule

// File: rtl/sg_addr_seq.sv
// Module: sg_addr_seq (top)
// Issues one host write address per accepted data word. The addresses come
// from a preloaded page table, so the host is not involved mid-transfer.
// Assumes: the table is written only while idle or finished.
// Entry MSB is the last-page flag. Page size is 2**PAGE_W words.
module sg_addr_seq #(
    parameter int ADDR_W    = 31,
    parameter int PAGE_W    = 12,
    parameter int TBL_DEPTH = 256,
    localparam int IDX_W    = $clog2(TBL_DEPTH),
    localparam int ENTRY_W  = ADDR_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tbl_we,
    input  logic [IDX_W-1:0]   tbl_idx,
    input  logic [ENTRY_W-1:0] tbl_data,
    input  logic               start,
    input  logic               abort,
    input  logic               word_stb,
    output logic               word_rdy,
    output logic [ADDR_W-1:0]  addr_out,
    output logic               addr_vld,
    output logic               done,
    output logic               overrun
);

    localparam int PNUM_W = ADDR_W - PAGE_W;

    logic [IDX_W-1:0]  rd_idx;
    logic [PNUM_W-1:0] rd_page;
    logic              rd_last;
    logic              busy;
    logic              load;
    logic              inc;
    logic              page_end;

    sg_table #(
        .ADDR_W    (ADDR_W),
        .PAGE_W    (PAGE_W),
        .TBL_DEPTH (TBL_DEPTH)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_we),
        .wr_idx  (tbl_idx),
        .wr_data (tbl_data),
        .busy    (busy),
        .rd_idx  (rd_idx),
        .rd_page (rd_page),
        .rd_last (rd_last)
    );

    sg_ptr #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .page_in  (rd_page),
        .inc      (inc),
        .addr     (addr_out),
        .page_end (page_end)
    );

    sg_ctrl #(
        .TBL_DEPTH (TBL_DEPTH)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .abort    (abort),
        .word_stb (word_stb),
        .page_end (page_end),
        .ent_last (rd_last),
        .rd_idx   (rd_idx),
        .busy     (busy),
        .load     (load),
        .inc      (inc),
        .word_rdy (word_rdy),
        .addr_vld (addr_vld),
        .done     (done),
        .overrun  (overrun)
    );

    AST_STALL_AFTER_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (word_stb && word_rdy && !abort && (&addr_out[PAGE_W-1:0])) |=> !word_rdy) // R4
        else $error("no stall after a page boundary");

    AST_DONE_NO_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !addr_vld) // R5
        else $error("address valid while done");

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !start && !abort) |=> (overrun && done)) // R7
        else $error("overrun dropped without start or abort");

    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!addr_vld && !done && !overrun)) // R9
        else $error("abort did not return to idle");

endmodule

// File: tb/sg_addr_seq_bench.sv
`timescale 1ns/1ps
module sg_addr_seq_bench;

    localparam int AW = 31;
    localparam int PW = 2;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_we = 1'b0;
    logic [2:0]  tbl_idx = '0;
    logic [31:0] tbl_data = '0;
    logic        start = 1'b0;
    logic        abort = 1'b0;
    logic        word_stb = 1'b0;
    logic        word_rdy;
    logic [30:0] addr_out;
    logic        addr_vld;
    logic        done;
    logic        overrun;

    int total = 0;
    int fail = 0;
    string cur_req = "R1";

    // Behavioural reference state.
    int          m_st = 0;   // 0 idle, 1 fetch, 2 run, 3 finished
    int          m_idx = 0;
    int          m_off = 0;
    logic [31:0] m_tbl [DEPTH];
    logic [30:0] m_base = '0;
    bit          m_last = 0;
    bit          m_done = 0;
    bit          m_ovr = 0;

    always #2 clk = ~clk;

    sg_addr_seq #(.ADDR_W(AW), .PAGE_W(PW), .TBL_DEPTH(DEPTH)) u_sg_addr_seq (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
        .tbl_data(tbl_data), .start(start), .abort(abort), .word_stb(word_stb),
        .word_rdy(word_rdy), .addr_out(addr_out), .addr_vld(addr_vld),
        .done(done), .overrun(overrun)
    );

    task automatic model_step();
        int prev;
        prev = m_st;
        if (!rst_n) begin
            m_st = 0; m_done = 0; m_ovr = 0; m_idx = 0; m_off = 0;
        end else begin
            if (abort) begin
                m_st = 0; m_done = 0; m_ovr = 0;
            end else if (m_st == 0) begin
                if (start) begin m_st = 1; m_idx = 0; end
            end else if (m_st == 3) begin
                if (start) begin m_st = 1; m_idx = 0; m_done = 0; m_ovr = 0; end
                else if (word_stb) m_ovr = 1;
            end else if (m_st == 1) begin
                m_base = m_tbl[m_idx][30:0] & ~31'd3;
                m_last = m_tbl[m_idx][31] || (m_idx == DEPTH - 1);
                m_idx = (m_idx + 1) % DEPTH;
                m_off = 0;
                m_st = 2;
            end else if (word_stb) begin
                if (m_off == 3) begin
                    if (m_last) begin m_st = 3; m_done = 1; end
                    else m_st = 1;
                end else m_off = m_off + 1;
            end
            if (tbl_we && prev != 1 && prev != 2) m_tbl[tbl_idx] = tbl_data;
        end
    endtask

    task automatic compare();
        bit e_run;
        bit bad;
        e_run = (m_st == 2);
        bad = (word_rdy !== e_run) || (addr_vld !== e_run) ||
              (done !== m_done) || (overrun !== m_ovr) ||
              (e_run && addr_out !== (m_base | 31'(m_off)));
        total++;
        if (bad) begin
            fail++;
            $display("FAIL %s cycle compare: actual rdy=%b vld=%b done=%b ovr=%b addr=%h expected rdy=%b vld=%b done=%b ovr=%b addr=%h",
                     cur_req, word_rdy, addr_vld, done, overrun, addr_out,
                     e_run, e_run, m_done, m_ovr, m_base | 31'(m_off));
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fail++;
            $display("FAIL %s explicit: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(int idx, logic [31:0] data);
        tbl_we = 1'b1; tbl_idx = 3'(idx); tbl_data = data;
        cyc();
        tbl_we = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) m_tbl[i] = '0;
        repeat (3) cyc();
        rst_n = 1'b1;
        cur_req = "R1";
        cyc();
        chk("R1", {28'd0, word_rdy, addr_vld, done, overrun}, 32'd0);
        for (int i = 0; i < DEPTH; i++) wr(i, 32'h0000_0100 * i);

        // Three-page transfer with continuous strobes, ending in overrun.
        cur_req = "R8";
        wr(0, 32'h0000_1235);
        wr(1, 32'h0004_0002);
        wr(2, 32'h8000_2008);
        cur_req = "R2";
        start = 1'b1; cyc(); start = 1'b0;
        chk("R2", {31'd0, word_rdy}, 32'd0);
        cyc();
        chk("R2", {1'b0, addr_out}, 32'h0000_1234);
        cur_req = "R4";
        word_stb = 1'b1;
        for (int i = 0; i < 30 && !done; i++) cyc();
        chk("R5", {30'd0, done, addr_vld}, 32'd2);
        cur_req = "R7";
        cyc();
        chk("R7", {30'd0, overrun, addr_vld}, 32'd2);
        word_stb = 1'b0;
        cyc();
        chk("R7", {30'd0, overrun, done}, 32'd3);

        // Start ignored while running; write ignored while running; abort.
        cur_req = "R9";
        start = 1'b1; cyc(); start = 1'b0;
        cyc();
        cur_req = "R10";
        start = 1'b1; cyc(); start = 1'b0;
        chk("R10", {addr_vld, addr_out}, 32'h8000_1234);
        cur_req = "R8";
        wr(0, 32'h0000_7770);
        cur_req = "R9";
        abort = 1'b1; cyc(); abort = 1'b0;
        chk("R9", {29'd0, addr_vld, done, overrun}, 32'd0);
        start = 1'b1; cyc(); start = 1'b0;
        cyc();
        chk("R8", {addr_vld, addr_out}, 32'h8000_1234);

        // Abort and start in the same cycle: abort wins.
        abort = 1'b1; start = 1'b1; cyc();
        abort = 1'b0; start = 1'b0;
        cyc();
        chk("R9", {31'd0, word_rdy}, 32'd0);
        cyc();
        chk("R9", {31'd0, word_rdy}, 32'd0);

        // Whole table without flags, gapped strobes.
        cur_req = "R6";
        for (int i = 0; i < DEPTH; i++) wr(i, 32'h0000_0040 + 32'h0000_1000 * i + 32'(i));
        start = 1'b1; cyc(); start = 1'b0;
        cyc();
        chk("R8", {1'b0, addr_out}, 32'h0000_0040);
        begin
            int acc;
            acc = 0;
            for (int i = 0; i < 200 && !done; i++) begin
                word_stb = (i % 3) != 0;
                if (word_stb && word_rdy) acc++;
                cyc();
            end
            word_stb = 1'b0;
            chk("R6", 32'(acc), 32'd32);
            chk("R6", {31'd0, done}, 32'd1);
        end
        cyc();
        chk("R3", {31'd0, overrun}, 32'd0);

        $display("%0d/%0d checks passed", total - fail, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; fail++;
        $display("FAIL R5 watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", total - fail, total);
        $finish;
    end

endmodule